// File: doc/BRIEF.md
# Queued Serial Byte Transmitter

This block turns a stream of bytes into an asynchronous serial bit stream. An upstream producer hands bytes over a valid/ready stream interface. Each accepted byte goes into a holding queue of up to 16 entries. A shift stage sends the oldest queued byte on a single output line. The framing has no parity: a low start bit, eight data bits sent least significant first, and one high stop bit.

Bit timing comes from a one-cycle enable pulse, `baud_tick`, that the surrounding logic supplies. The line moves to the next bit only on a clock edge where that pulse is high. When a stop bit ends and another byte is waiting, the shift stage reloads straight from the queue head. The next start bit therefore follows with no idle bit between frames.

Back-pressure rules: a byte transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops while the queue holds 16 bytes. A producer holding `in_valid` high must keep `in_data` stable until the transfer edge. While `in_valid` is low, `in_data` is don't-care.

Top module: `uart_tx_queued`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the queue, stops any frame in progress, drives `tx_line` high and raises `in_ready`. No byte queued before the reset is ever sent.
- R2: A byte is taken only on an edge where `in_valid` and `in_ready` are both high. While `in_valid` is low, `in_data` has no effect and the line stays idle.
- R3: `in_ready` is low exactly while the queue holds 16 bytes. A byte offered while `in_ready` is low is not stored and is never transmitted.
- R4: Each frame is 10 bit periods long: one low start bit, then data bit 0 through data bit 7, then one high stop bit.
- R5: The line state changes only on edges where `baud_tick` is high. A queued byte does not start while ticks are absent. Each bit lasts from one tick edge to the next.
- R6: Bytes leave in the order they were accepted.
- R7: If the queue is not empty when a stop bit ends, the next start bit begins on that same tick edge, with no idle period between frames.
- R8: `tx_line` is high whenever no frame is in progress. After the last queued byte's stop bit, the line stays high.
- R9: A byte accepted on the same edge that the shift stage loads from the queue is stored correctly and sent next. The queue occupancy is unchanged by that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Byte offered by the producer |
| in_valid | input | 1 | Producer has a byte on `in_data` this cycle |
| in_ready | output | 1 | Queue can accept a byte on this edge |
| baud_tick | input | 1 | One-cycle pulse marking a bit-period boundary |
| tx_line | output | 1 | Serial output, idle high |

## Verification
A transfer edge updates the queue occupancy at once, so `in_ready` is checked on the falling edge right after the 16th transfer. The line is a register. It shows a new bit immediately after a rising edge on which `baud_tick` was high. For a non-empty idle queue, that edge carries the start bit; after it come one bit per tick, and the next frame's start bit follows the stop bit with no gap. The bench finds each bit boundary by waiting for a falling edge on which the tick is high, then samples the line on the following falling edge. Frames are collected as one continuous stream of 10-bit slots, so any extra idle bit between frames shifts every later slot and is detected.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  // Serial framing: start + data + stop
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 2;

  typedef enum logic {
    SH_IDLE  = 1'b0,
    SH_FRAME = 1'b1
  } shift_state_e;

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q;
  logic [AW-1:0]    rd_ptr_q;
  logic [CW-1:0]    count_q;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // Storage: only the slot under the write pointer takes the new byte
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_ptr_q == AW'(i))) slot_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= advance(wr_ptr_q);
      if (rd_en) rd_ptr_q <= advance(rd_ptr_q);
      case ({wr_en, rd_en})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_data = slot_q[rd_ptr_q];
  assign empty   = (count_q == '0);
  assign full    = (count_q == CW'(DEPTH));

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> empty);                                                   // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> full);                                       // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);                                                // R6
  AST_PUSH_POP_STEADY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> $stable(count_q));                           // R9

endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
  import uart_txq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             have_data,
  input  logic [WIDTH-1:0] head_data,
  output logic             take,
  output logic             tx
);

  localparam int LAST = WIDTH + 1;            // index of the stop bit
  localparam int CNTW = $clog2(LAST + 1);

  shift_state_e     state_q;
  logic [WIDTH:0]   sreg_q;                   // data bits plus stop bit
  logic [CNTW-1:0]  bit_q;
  logic             tx_q;
  logic             frame_end;

  assign frame_end = (state_q == SH_FRAME) && (bit_q == CNTW'(LAST));
  // Load from the queue head when idle or when the stop bit is ending
  assign take = tick && have_data && ((state_q == SH_IDLE) || frame_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SH_IDLE;
      sreg_q  <= '1;
      bit_q   <= '0;
      tx_q    <= 1'b1;
    end else if (tick) begin
      if (take) begin
        state_q <= SH_FRAME;
        sreg_q  <= {1'b1, head_data};
        bit_q   <= '0;
        tx_q    <= 1'b0;
      end else if (frame_end) begin
        state_q <= SH_IDLE;
        tx_q    <= 1'b1;
      end else if (state_q == SH_FRAME) begin
        tx_q    <= sreg_q[0];
        sreg_q  <= {1'b1, sreg_q[WIDTH:1]};
        bit_q   <= bit_q + 1'b1;
      end
    end
  end

  assign tx = tx_q;

  AST_RESET_LINE_HIGH: assert property (@(posedge clk)
    rst |=> tx);                                                      // R1
  AST_STEADY_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tx));                                           // R5
  AST_LOAD_START_LOW: assert property (@(posedge clk) disable iff (rst)
    take |=> !tx);                                                    // R4
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state_q == SH_IDLE) |-> tx);                                     // R8

endmodule

// File: rtl/uart_tx_queued.sv
module uart_tx_queued
  import uart_txq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              baud_tick,
  output logic              tx_line
);

  logic              push;
  logic              pop;
  logic              q_empty;
  logic              q_full;
  logic [BYTE_W-1:0] q_head;

  assign in_ready = !q_full;
  assign push     = in_valid && in_ready;

  txq_fifo #(
    .WIDTH (BYTE_W),
    .DEPTH (DEPTH)
  ) u_queue (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push),
    .wr_data (in_data),
    .rd_en   (pop),
    .rd_data (q_head),
    .empty   (q_empty),
    .full    (q_full)
  );

  txq_shifter #(
    .WIDTH (BYTE_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .have_data (!q_empty),
    .head_data (q_head),
    .take      (pop),
    .tx        (tx_line)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (q_full && !pop) |=> !in_ready);                                  // R3
  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && q_empty && !pop) |=> q_empty);                      // R2

endmodule

// File: tb/uart_tx_queued_bench.sv
`timescale 1ns/1ps
module uart_tx_queued_bench;

  localparam int DIV = 8;

  typedef struct packed {
    logic [7:0] data;
    logic [9:0] frame;   // frame[0] = start ... frame[9] = stop
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'h55, 10'b1_01010101_0},
    '{8'hA3, 10'b1_10100011_0},
    '{8'h00, 10'b1_00000000_0},
    '{8'hFF, 10'b1_11111111_0},
    '{8'h81, 10'b1_10000001_0},
    '{8'h3C, 10'b1_00111100_0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       baud_tick;
  logic       tx_line;
  logic       tick_en = 1'b0;
  logic [3:0] div_q;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  logic [9:0] got [16];
  logic       idle_after;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!tick_en) begin
      div_q     <= '0;
      baud_tick <= 1'b0;
    end else begin
      div_q     <= (div_q == DIV - 1) ? '0 : div_q + 1'b1;
      baud_tick <= (div_q == DIV - 1);
    end
  end

  uart_tx_queued u_uart_tx_queued (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .baud_tick (baud_tick),
    .tx_line   (tx_line)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    while (in_ready !== 1'b1) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic next_period();
    do @(negedge clk); while (baud_tick !== 1'b1);
    @(negedge clk);
  endtask

  // Continuous stream of n frames from the first start bit, then one idle slot
  task automatic capture(input int n);
    do @(negedge clk); while (tx_line !== 1'b0);
    for (int f = 0; f < n; f++) begin
      for (int b = 0; b < 10; b++) begin
        if (!(f == 0 && b == 0)) next_period();
        got[f][b] = tx_line;
      end
    end
    next_period();
    idle_after = tx_line;
  endtask

  initial begin
    #(150000 * 8);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    bit quiet;
    // R1: reset state
    do_reset();
    @(negedge clk);
    check(tx_line === 1'b1, "R1 line high after reset", tx_line, 1);
    check(in_ready === 1'b1, "R1 ready after reset", in_ready, 1);

    // R2: data wiggles with valid low, ticks running: nothing sent
    tick_en = 1'b1;
    quiet = 1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      in_data = 8'(i * 37);
      if (tx_line !== 1'b1) quiet = 0;
    end
    check(quiet, "R2 data ignored without valid", quiet, 1);

    // R4 R6 R7 R8: table walk, frames back to back
    tick_en = 1'b0;
    foreach (VEC[k]) push(VEC[k].data);
    tick_en = 1'b1;
    capture(6);
    foreach (VEC[k])
      check(got[k] === VEC[k].frame, "R4 R6 R7 frame in stream", got[k], VEC[k].frame);
    check(idle_after === 1'b1, "R8 idle after last stop", idle_after, 1);

    // R5: no start while ticks are absent, start follows first tick
    do_reset();
    push(8'h96);
    quiet = 1;
    repeat (60) begin
      @(negedge clk);
      if (tx_line !== 1'b1) quiet = 0;
    end
    check(quiet, "R5 held without ticks", quiet, 1);
    tick_en = 1'b1;
    capture(1);
    check(got[0] === 10'b1_10010110_0, "R5 frame after ticks resume", got[0], 10'b1_10010110_0);

    // R3: fill to 16, ready low, extra offer dropped
    do_reset();
    for (int i = 0; i < 15; i++) push(8'(8'h10 + i));
    check(in_ready === 1'b1, "R3 ready with 15 queued", in_ready, 1);
    push(8'h1F);
    check(in_ready === 1'b0, "R3 ready low with 16 queued", in_ready, 0);
    in_valid = 1'b1; in_data = 8'hEE;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    check(in_ready === 1'b0, "R3 stays full under offers", in_ready, 0);
    tick_en = 1'b1;
    capture(16);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++)
        if (got[i] !== {1'b1, 8'(8'h10 + i), 1'b0}) bad++;
      check(bad == 0, "R3 R6 sixteen frames in order", bad, 0);
    end
    check(idle_after === 1'b1, "R3 offer while full not sent", idle_after, 1);

    // R9: accept on the same edge the shifter loads
    do_reset();
    push(8'h5A);
    tick_en = 1'b1;
    do @(negedge clk); while (baud_tick !== 1'b1);
    in_valid = 1'b1; in_data = 8'hC3;
    fork
      begin @(negedge clk); in_valid = 1'b0; end
      capture(2);
    join
    check(got[0] === 10'b1_01011010_0, "R9 first frame", got[0], 10'b1_01011010_0);
    check(got[1] === 10'b1_11000011_0, "R9 byte taken during load", got[1], 10'b1_11000011_0);
    check(idle_after === 1'b1, "R9 nothing extra queued", idle_after, 1);

    // R1: reset in mid-frame discards queue
    do_reset();
    push(8'h01); push(8'h02); push(8'h03);
    tick_en = 1'b1;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_line === 1'b1, "R1 line high after mid-frame reset", tx_line, 1);
    check(in_ready === 1'b1, "R1 ready after mid-frame reset", in_ready, 1);
    quiet = 1;
    repeat (15 * DIV) begin
      @(negedge clk);
      if (tx_line !== 1'b1) quiet = 0;
    end
    check(quiet, "R1 queued bytes dropped", quiet, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule